// File: doc/BRIEF.md
# Abortable Progressive Video Timing Generator

This block produces a progressive video stream as one 10-bit multiplexed word per clock. The stream has the embedded timing reference codes used by BT.1120-style links, so a downstream capture port can lock onto line and frame boundaries without separate sync wires. Each line starts with an end-of-active-video code. A horizontal blanking gap follows, then a start-of-active-video code, then the active region. In ordinary frames, every line and every frame has the same fixed geometry.

A single-cycle trigger pulse can cut an ordinary frame short. The line in progress runs to its normal end. Every remaining line of the frame is then emitted as a short filler line, so the receiver still counts the full number of lines. The frame that follows is the trigger frame: it is always emitted at full length, and the `trig_frame` output flags it.

The line sequencer (`ftg_hline`) has four named states. `H_EAV` always moves to `H_BLANK`, `H_BLANK` to `H_SAV`, `H_SAV` to `H_ACT`, and `H_ACT` back to `H_EAV`, which closes the line. Each state holds for a number of words set by a parameter. The frame sequencer (`ftg_frame_seq`) has two modes. `F_NORMAL` moves to `F_PAD` at the end of a line in which an abort was accepted. `F_PAD` returns to `F_NORMAL` at the end of the frame's last line. It also holds one pending-trigger bit and the trigger-frame flag.

Top module: `bt1120_abort_gen`

## Requirements
- R1: Every line is a 4-word EAV code, then `HBLANK` blanking words, then a 4-word SAV code, then the active region. The active region is `ACT_LEN` words in a normal line and `FILL_LEN` words in a filler line. A normal line is therefore `HBLANK+ACT_LEN+8` cycles long.
- R2: Each timing code is 3FFh, 000h, 000h, XYZ. XYZ is {1, F=0, V, H, V^H, H, V, V^H, 0, 0}, where H=1 marks EAV. The only legal XYZ values are therefore 200h, 274h, 2ACh and 2D8h. The value 3FFh appears only as the first code word.
- R3: In an ordinary line, V is 1 on lines 1 to `ACT_FIRST-1` and on line `LINES`, and 0 on all other lines. The active region of a V=0 line carries `pix_in` unchanged. `pix_in` must stay within 004h to 3FBh.
- R4: Every blanking word alternates between 200h (even offset in the region) and 040h (odd offset). This covers the horizontal gap and the active region of V=1 lines and filler lines.
- R5: A trigger during line N of an ordinary frame, with N < `LINES`, lets line N finish normally. Lines N+1 to `LINES` are then filler lines with V=1, giving `LINES-N` filler lines.
- R6: The frame after a padded frame is a full-length trigger frame. `trig_frame` is 1 for all of it and changes only at frame starts.
- R7: A trigger during the last line of an ordinary frame is held. That frame gets no filler lines, and the next frame is a trigger frame.
- R8: A trigger during padding merges with the abort already under way. Exactly one trigger frame follows, and the frame after it is ordinary.
- R9: A trigger during a trigger frame does not shorten that frame. The following frame is also a trigger frame.
- R10: `frame_start` is 1 only on the first EAV word of line 1. An ordinary frame lasts `LINES` normal lines.
- R11: During reset the output is the first EAV word of line 1: `vid_out`=3FFh, `frame_start`=1 and `trig_frame`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 10 | Pixel word placed in active regions of active lines |
| trig_in | input | 1 | Single-cycle trigger request |
| vid_out | output | 10 | Multiplexed video word with embedded timing codes |
| frame_start | output | 1 | High on the first word of each frame |
| trig_frame | output | 1 | High for the whole of a trigger frame |

## Verification
The bench builds the block with `HBLANK`=4, `ACT_LEN`=8, `FILL_LEN`=2, `LINES`=6 and `ACT_FIRST`=3. This gives 20-cycle normal lines, 14-cycle filler lines and 120-cycle frames. At that size, triggers can be placed in the first line, in an active line, in the line just before the last, in the last line, inside padding and inside a trigger frame, all within a few dozen frames. Each frame is rebuilt from the decoded output stream as counts of normal, filler and active lines and its length in cycles. These counts are compared with figures derived from the requirements.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [1:0] {H_EAV, H_BLANK, H_SAV, H_ACT} h_state_t;
    typedef enum logic {F_NORMAL, F_PAD} f_mode_t;

    localparam logic [9:0] CODE_LEAD = 10'h3FF;
    localparam logic [9:0] CODE_ZERO = 10'h000;
    localparam logic [9:0] BLANK_C   = 10'h200;
    localparam logic [9:0] BLANK_Y   = 10'h040;

    // Fourth code word: field bit fixed at 0, protection bits derived from V and H.
    function automatic logic [9:0] xyz_word(input logic v, input logic h);
        return {1'b1, 1'b0, v, h, v ^ h, h, v, v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/ftg_hline.sv
module ftg_hline
    import ftg_pkg::*;
#(
    parameter int HBLANK   = 128,
    parameter int ACT_LEN  = 1934,
    parameter int FILL_LEN = 24,
    parameter int CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          short_line,
    output h_state_t      state,
    output logic [CW-1:0] pos,
    output logic          line_end
);

    h_state_t      state_nx;
    logic [CW-1:0] pos_nx;
    logic [CW-1:0] last_pos;

    always_comb begin
        unique case (state)
            H_EAV:   last_pos = CW'(3);
            H_BLANK: last_pos = CW'(HBLANK - 1);
            H_SAV:   last_pos = CW'(3);
            H_ACT:   last_pos = short_line ? CW'(FILL_LEN - 1) : CW'(ACT_LEN - 1);
        endcase
        state_nx = state;
        pos_nx   = pos + CW'(1);
        if (pos == last_pos) begin
            pos_nx = '0;
            unique case (state)
                H_EAV:   state_nx = H_BLANK;
                H_BLANK: state_nx = H_SAV;
                H_SAV:   state_nx = H_ACT;
                H_ACT:   state_nx = H_EAV;
            endcase
        end
        line_end = (state == H_ACT) && (pos == last_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= H_EAV;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

endmodule

// File: rtl/ftg_frame_seq.sv
module ftg_frame_seq
    import ftg_pkg::*;
#(
    parameter int LINES     = 1213,
    parameter int ACT_FIRST = 3,
    parameter int LW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          trig_in,
    output logic [LW-1:0] line,
    output logic          pad,
    output logic          trig_frame,
    output logic          v_bit
);

    f_mode_t       mode, mode_nx;
    logic [LW-1:0] line_nx;
    logic          abort_req, abort_nx;
    logic          pending, pending_nx;
    logic          tf_nx;
    logic          last_line, trig_abort, abort_now, pend_now;

    always_comb begin
        last_line  = (line == LW'(LINES));
        trig_abort = trig_in && (mode == F_NORMAL) && !trig_frame && !last_line && !abort_req;
        abort_now  = abort_req || trig_abort;
        pend_now   = pending || (trig_in && !trig_abort);

        mode_nx    = mode;
        line_nx    = line;
        abort_nx   = abort_now;
        pending_nx = pend_now;
        tf_nx      = trig_frame;
        if (line_end) begin
            abort_nx = 1'b0;
            if (last_line) begin
                line_nx    = LW'(1);
                mode_nx    = F_NORMAL;
                pending_nx = 1'b0;
                tf_nx      = (mode == F_PAD) || pend_now;
            end else begin
                line_nx = line + LW'(1);
                unique case (mode)
                    F_NORMAL: mode_nx = abort_now ? F_PAD : F_NORMAL;
                    F_PAD:    mode_nx = F_PAD;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= F_NORMAL;
            line       <= LW'(1);
            abort_req  <= 1'b0;
            pending    <= 1'b0;
            trig_frame <= 1'b0;
        end else begin
            mode       <= mode_nx;
            line       <= line_nx;
            abort_req  <= abort_nx;
            pending    <= pending_nx;
            trig_frame <= tf_nx;
        end
    end

    always_comb begin
        pad   = (mode == F_PAD);
        v_bit = pad || (line < LW'(ACT_FIRST)) || last_line;
    end

endmodule

// File: rtl/ftg_word_mux.sv
module ftg_word_mux
    import ftg_pkg::*;
(
    input  h_state_t   state,
    input  logic [1:0] pos_lsb,
    input  logic       v_bit,
    input  logic [9:0] pix_in,
    output logic [9:0] word
);

    logic [9:0] blank_word;
    logic [9:0] code_word;

    always_comb begin
        blank_word = pos_lsb[0] ? BLANK_Y : BLANK_C;
        unique case (pos_lsb)
            2'd0:    code_word = CODE_LEAD;
            2'd3:    code_word = xyz_word(v_bit, state == H_EAV);
            default: code_word = CODE_ZERO;
        endcase
        unique case (state)
            H_EAV, H_SAV: word = code_word;
            H_BLANK:      word = blank_word;
            H_ACT:        word = v_bit ? blank_word : pix_in;
        endcase
    end

endmodule

// File: rtl/bt1120_abort_gen.sv
module bt1120_abort_gen
    import ftg_pkg::*;
#(
    parameter int HBLANK    = 128,
    parameter int ACT_LEN   = 1934,
    parameter int FILL_LEN  = 24,
    parameter int LINES     = 1213,
    parameter int ACT_FIRST = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [9:0] pix_in,
    input  logic       trig_in,
    output logic [9:0] vid_out,
    output logic       frame_start,
    output logic       trig_frame
);

    localparam int MAXLEN = (HBLANK > ACT_LEN) ? HBLANK : ACT_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam int LW     = $clog2(LINES + 1);

    h_state_t      h_state;
    logic [CW-1:0] h_pos;
    logic          line_end;
    logic [LW-1:0] line_no;
    logic          pad_mode;
    logic          v_bit;

    ftg_hline #(
        .HBLANK(HBLANK), .ACT_LEN(ACT_LEN), .FILL_LEN(FILL_LEN), .CW(CW)
    ) u_hline (
        .clk(clk), .rst_n(rst_n), .short_line(pad_mode),
        .state(h_state), .pos(h_pos), .line_end(line_end)
    );

    ftg_frame_seq #(
        .LINES(LINES), .ACT_FIRST(ACT_FIRST), .LW(LW)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .trig_in(trig_in),
        .line(line_no), .pad(pad_mode), .trig_frame(trig_frame), .v_bit(v_bit)
    );

    ftg_word_mux u_mux (
        .state(h_state), .pos_lsb(h_pos[1:0]), .v_bit(v_bit),
        .pix_in(pix_in), .word(vid_out)
    );

    assign frame_start = (line_no == LW'(1)) && (h_state == H_EAV) && (h_pos == '0);

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] dout,
    input logic       sof,
    input logic       trig_frame,
    input logic       pad
);

    p_xyz_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dout, 3) == 10'h3FF && $past(dout, 2) == 10'h000 && $past(dout, 1) == 10'h000)
        |-> (dout == 10'h200 || dout == 10'h274 || dout == 10'h2AC || dout == 10'h2D8));

    p_code_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dout == 10'h3FF |=> dout == 10'h000);

    p_sof_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> dout == 10'h3FF);

    p_tf_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |-> $stable(trig_frame));

    p_pad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pad |=> (pad || sof));

    p_tf_nopad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_frame |-> !pad);

endmodule

bind bt1120_abort_gen ftg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dout(vid_out), .sof(frame_start),
    .trig_frame(trig_frame), .pad(pad_mode)
);

// File: tb/bt1120_abort_gen_tb.sv
module bt1120_abort_gen_tb;

    localparam int HB = 4, ACT = 8, FILL = 2, LINES = 6, AFIRST = 3;
    localparam int NLEN = HB + ACT + 8;
    localparam int NACT = LINES - AFIRST;

    logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
    logic [9:0] pix = 10'h100;
    logic [9:0] dout;
    logic sof, tfr;

    always #4 clk = ~clk;

    bt1120_abort_gen #(.HBLANK(HB), .ACT_LEN(ACT), .FILL_LEN(FILL),
                       .LINES(LINES), .ACT_FIRST(AFIRST)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix), .trig_in(trig),
        .vid_out(dout), .frame_start(sof), .trig_frame(tfr));

    int tests = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream monitor
    int tcyc, t_sav, t_eav, t_sof, fcount, ridx;
    bit have_sav, have_eav, bnd, started, cur_trg, new_trg;
    int nn, nf, na, kind, ridx_blank;
    int bad_code, bad_len, bad_pix, bad_blank;
    logic [9:0] p1, p2, p3;
    int rec_norm [64];
    int rec_fill [64];
    int rec_na   [64];
    int rec_trg  [64];
    int flen     [64];

    initial begin
        forever begin
            @(posedge clk);
            #2 pix = (pix == 10'h2FF) ? 10'h100 : pix + 10'd1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            tcyc = 0; have_sav = 0; have_eav = 0; bnd = 0; started = 0;
            nn = 0; nf = 0; na = 0; kind = 0; fcount = 0; ridx = 0;
            p1 = 0; p2 = 0; p3 = 0; cur_trg = 0; new_trg = 0;
        end else begin
            tcyc++;
            if (sof) begin
                bnd = 1; new_trg = tfr;
                if (fcount > 0 && fcount <= 64) flen[fcount-1] = tcyc - t_sof;
                t_sof = tcyc; fcount++;
            end
            if (p3 == 10'h3FF && p2 == 10'h000 && p1 == 10'h000) begin
                if (!(dout inside {10'h200, 10'h274, 10'h2AC, 10'h2D8})) bad_code++;
                if (dout[6]) begin
                    if (have_sav) begin
                        if (tcyc - t_sav - 4 == ACT) nn++;
                        else if (tcyc - t_sav - 4 == FILL) nf++;
                        else bad_len++;
                    end
                    t_eav = tcyc; have_eav = 1; kind = 1;
                    if (bnd) begin
                        if (started && ridx < 64) begin
                            rec_norm[ridx] = nn; rec_fill[ridx] = nf;
                            rec_na[ridx] = na; rec_trg[ridx] = cur_trg; ridx++;
                        end
                        started = 1; nn = 0; nf = 0; na = 0; cur_trg = new_trg; bnd = 0;
                    end
                end else begin
                    if (have_eav && tcyc - t_eav - 4 != HB) bad_len++;
                    t_sav = tcyc; have_sav = 1;
                    kind = dout[7] ? 1 : 2;
                    if (!dout[7]) na++;
                end
                ridx_blank = 0;
            end else if (dout == 10'h3FF) begin
                kind = 0;
            end else if (kind == 1) begin
                if (dout != ((ridx_blank % 2) ? 10'h040 : 10'h200)) bad_blank++;
                ridx_blank++;
            end else if (kind == 2) begin
                if (dout != pix) bad_pix++;
            end
            p3 = p2; p2 = p1; p1 = dout;
        end
    end

    task automatic wait_sof(output int fid);
        do begin @(negedge clk); #1; end while (!sof);
        fid = fcount - 1;
    endtask

    task automatic pulse(input int gap);
        repeat (gap) @(negedge clk);
        #1 trig = 1'b1;
        @(negedge clk);
        #1 trig = 1'b0;
    endtask

    task automatic settle(input int nsof);
        int dummy;
        repeat (nsof) wait_sof(dummy);
        repeat (6) @(negedge clk);
    endtask

    // {trigger line, offset in line, expected fillers, expected active lines}
    typedef struct packed { int ln; int off; int fill; int nact; } vec_t;
    localparam vec_t VECS [4] = '{
        '{1, 2, 5, 0},
        '{3, 15, 3, 1},
        '{5, 10, 1, 3},
        '{6, 5, 0, 3}
    };

    initial begin
        int fid;
        int fid2;
        bad_code = 0; bad_len = 0; bad_pix = 0; bad_blank = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout == 10'h3FF, "R11 vid_out", dout, 10'h3FF);
        chk(sof == 1'b1, "R11 frame_start", sof, 1);
        chk(tfr == 1'b0, "R11 trig_frame", tfr, 0);
        #1 rst_n = 1'b1;

        settle(2);
        chk(flen[0] == LINES * NLEN, "R10 ordinary frame length", flen[0], LINES * NLEN);
        chk(rec_trg[0] == 0 && rec_fill[0] == 0, "R10 ordinary frame", rec_fill[0], 0);

        for (int i = 0; i < 4; i++) begin
            wait_sof(fid);
            pulse((VECS[i].ln - 1) * NLEN + VECS[i].off);
            settle(2);
            chk(rec_fill[fid] == VECS[i].fill, (VECS[i].ln == LINES) ? "R7 fillers" : "R5 fillers",
                rec_fill[fid], VECS[i].fill);
            chk(rec_norm[fid] == LINES - VECS[i].fill, "R5 normal lines", rec_norm[fid],
                LINES - VECS[i].fill);
            chk(rec_na[fid] == VECS[i].nact, "R3 active lines in padded frame", rec_na[fid],
                VECS[i].nact);
            chk(rec_trg[fid + 1] == 1, "R6 trigger frame flag", rec_trg[fid + 1], 1);
            chk(rec_norm[fid + 1] == LINES && rec_fill[fid + 1] == 0, "R6 trigger frame complete",
                rec_norm[fid + 1], LINES);
            chk(rec_na[fid + 1] == NACT, "R3 trigger frame active lines", rec_na[fid + 1], NACT);
            chk(flen[fid + 1] == LINES * NLEN, "R10 trigger frame length", flen[fid + 1],
                LINES * NLEN);
        end

        // R8: second trigger inside padding
        wait_sof(fid);
        pulse(NLEN + 3);
        pulse(3 * NLEN + 3 - (NLEN + 4));
        settle(3);
        chk(rec_fill[fid] == LINES - 2, "R8 fillers", rec_fill[fid], LINES - 2);
        chk(rec_trg[fid + 1] == 1, "R8 one trigger frame", rec_trg[fid + 1], 1);
        chk(rec_trg[fid + 2] == 0, "R8 merged trigger", rec_trg[fid + 2], 0);

        // R9: trigger inside a trigger frame
        wait_sof(fid);
        pulse(NLEN + 1);
        wait_sof(fid2);
        pulse(2 * NLEN + 2);
        settle(2);
        chk(rec_trg[fid2] == 1 && rec_fill[fid2] == 0, "R9 trigger frame not shortened",
            rec_fill[fid2], 0);
        chk(rec_trg[fid2 + 1] == 1, "R9 next trigger frame", rec_trg[fid2 + 1], 1);
        chk(rec_fill[fid2 + 1] == 0, "R9 next frame complete", rec_fill[fid2 + 1], 0);

        chk(bad_code == 0, "R2 timing code words", bad_code, 0);
        chk(bad_len == 0, "R1 region lengths", bad_len, 0);
        chk(bad_pix == 0, "R3 pixel passthrough", bad_pix, 0);
        chk(bad_blank == 0, "R4 blanking words", bad_blank, 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule